// File: doc/BRIEF.md
# Escalating Watchdog With Unlock-Protected Stop

The block is a watchdog that does not keep its own time base. It counts expiry pulses from one of several external periodic countdown timers, selected by software, and groups a programmable number of those pulses into one watchdog stage. After a start command it climbs through five stages. Each of the first four raises whichever interrupt outputs are enabled, giving software the chance to service the watchdog. The fifth raises the enabled reset outputs and holds them until the chip is reset.

Software talks to it through four word registers on a plain synchronous port: configuration, command, status and key. Servicing means stopping and restarting, which puts the stage count back to zero. A stop is honoured only if the key value was written just before it, so a runaway program cannot easily switch the watchdog off. While the watchdog runs with its first interrupt enabled, the configuration cannot be changed.

Top module: `esc_watchdog`

## Requirements
- R1: After reset, every output is low, the configuration register reads 0 and the status register reads 0.
- R2: The configuration register (address 0) holds the timer select in bits 3:0, the stage length in timer pulses in bits 11:4, and the enables in bits 12 (first interrupt), 13 (fast interrupt), 14 (remote interrupt), 15 (debug reset) and 16 (power-on reset). Bits 31:17 read as 0.
- R3: Writing 1 to bit 0 at the command address (1) sets the running flag and clears the stage. The status register (address 2) shows the running flag in bit 0 and the stage number in bits 3:1.
- R4: While running, the stage goes up by one once the selected timer input has pulsed as many times as the stage length. A length of 0 counts as 1. Pulses on inputs that are not selected have no effect.
- R5: When stages 1 to 4 are reached, each enabled interrupt output gives a pulse of one cycle, in the cycle after the timer pulse that ends the stage. Outputs that are not enabled stay low.
- R6: When stage 5 is reached, the power-on reset output and the debug reset output go high if they are enabled. Each stays high until a hardware reset. No interrupts are raised at that point, and later timer pulses leave the stage at 5.
- R7: A stop (bit 1 at the command address) is ignored unless 0x0000C45A was written to the key address (3) beforehand.
- R8: The key permission is used up by the next command write, whatever that write holds. An accepted stop clears the running flag.
- R9: Writes to the configuration register are ignored while the watchdog runs with the first-interrupt enable set. They are accepted again once it has been stopped.
- R10: A start while the watchdog is running returns the stage and the pulse count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 config, 1 command, 2 status, 3 key |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tick_src | input | NUM_SRC | One expiry pulse input per external timer |
| irq_local | output | 1 | First interrupt pulse |
| irq_fast | output | 1 | Fast interrupt pulse |
| irq_remote | output | 1 | Remote interrupt pulse |
| dbg_rst | output | 1 | Debug reset, held once set |
| por_rst | output | 1 | Power-on reset, held once set |

## Verification
The assertions expect each timer input to be a pulse synchronous to clk and register writes to be presented for exactly one clock. They also expect NUM_SRC to be no larger than sixteen, so the select field covers every input. The bench drives all inputs on the falling edge. It holds a timer pulse for a single cycle with gaps between pulses, so every stage transition and every interrupt pulse can be seen on its own. Pulses on an input that is not selected are sent on purpose, and those too last one cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SRC_W     = 4;
  localparam int PER_W     = 8;
  localparam int STAGE_W   = 3;
  localparam int LAST_STG  = 5;
  localparam int CFG_W     = SRC_W + PER_W + 5;
  localparam int MAX_SRC   = 1 << SRC_W;
  localparam logic [31:0] KEY_VALUE = 32'h0000_C45A;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_KEY  = 2'd3;

  // Field order fixes the software-visible bit positions (LSB last).
  typedef struct packed {
    logic             por_en;
    logic             dbg_en;
    logic             remote_en;
    logic             fast_en;
    logic             local_en;
    logic [PER_W-1:0] period;
    logic [SRC_W-1:0] src;
  } cfg_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        running,
  output cfg_t        cfg_q,
  output logic        key_q,
  output logic        start_p,
  output logic        stop_p
);
  logic cmd_wr, cfg_wr, key_wr, locked;

  assign cmd_wr  = we && (addr == A_CMD);
  assign cfg_wr  = we && (addr == A_CFG);
  assign key_wr  = we && (addr == A_KEY);
  assign locked  = running && cfg_q.local_en;
  assign stop_p  = cmd_wr && wdata[1] && key_q;
  assign start_p = cmd_wr && wdata[0] && !stop_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      key_q <= 1'b0;
    end else begin
      if (cfg_wr && !locked) cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
      if (cmd_wr)            key_q <= 1'b0;
      else if (key_wr)       key_q <= (wdata == KEY_VALUE);
    end
  end
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
  import wdg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PER_W-1:0]   period,
  input  logic               start_p,
  input  logic               stop_p,
  output logic               running_q,
  output logic [STAGE_W-1:0] stage_q,
  output logic               expire,
  output logic [STAGE_W-1:0] next_stage
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   eff_len, cnt_inc;
  logic             active, counting;

  assign eff_len    = (period == '0) ? (PER_W+1)'(1) : {1'b0, period};
  assign cnt_inc    = {1'b0, cnt_q} + (PER_W+1)'(1);
  assign active     = running_q && (stage_q != STAGE_W'(LAST_STG));
  assign counting   = active && tick && !start_p && !stop_p;
  assign expire     = counting && (cnt_inc >= eff_len);
  assign next_stage = stage_q + STAGE_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      stage_q   <= '0;
      cnt_q     <= '0;
    end else if (start_p) begin
      running_q <= 1'b1;
      stage_q   <= '0;
      cnt_q     <= '0;
    end else if (stop_p) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (expire) begin
      stage_q   <= next_stage;
      cnt_q     <= '0;
    end else if (counting) begin
      cnt_q     <= cnt_inc[PER_W-1:0];
    end
  end
endmodule

// File: rtl/wdg_outputs.sv
module wdg_outputs
  import wdg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               expire,
  input  logic [STAGE_W-1:0] next_stage,
  input  cfg_t               cfg,
  output logic               irq_local,
  output logic               irq_fast,
  output logic               irq_remote,
  output logic               dbg_rst,
  output logic               por_rst
);
  logic warn, final_hit;

  assign final_hit = expire && (next_stage == STAGE_W'(LAST_STG));
  assign warn      = expire && !final_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_local  <= 1'b0;
      irq_fast   <= 1'b0;
      irq_remote <= 1'b0;
      dbg_rst    <= 1'b0;
      por_rst    <= 1'b0;
    end else begin
      irq_local  <= warn && cfg.local_en;
      irq_fast   <= warn && cfg.fast_en;
      irq_remote <= warn && cfg.remote_en;
      dbg_rst    <= dbg_rst || (final_hit && cfg.dbg_en);
      por_rst    <= por_rst || (final_hit && cfg.por_en);
    end
  end
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
  import wdg_pkg::*;
#(
  parameter int NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_addr,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] tick_src,
  output logic               irq_local,
  output logic               irq_fast,
  output logic               irq_remote,
  output logic               dbg_rst,
  output logic               por_rst
);
  cfg_t               cfg_q;
  logic               key_q, start_p, stop_p;
  logic               run_q, expire, sel_tick;
  logic [STAGE_W-1:0] stage_q, next_stage;
  logic [MAX_SRC-1:0] tick_pad;

  for (genvar i = 0; i < MAX_SRC; i++) begin : g_pad
    if (i < NUM_SRC) begin : g_live
      assign tick_pad[i] = tick_src[i];
    end else begin : g_dead
      assign tick_pad[i] = 1'b0;
    end
  end

  assign sel_tick = tick_pad[cfg_q.src];

  wdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .running(run_q), .cfg_q(cfg_q), .key_q(key_q), .start_p(start_p), .stop_p(stop_p)
  );

  wdg_stage u_stage (
    .clk(clk), .rst_n(rst_n), .tick(sel_tick), .period(cfg_q.period),
    .start_p(start_p), .stop_p(stop_p), .running_q(run_q), .stage_q(stage_q),
    .expire(expire), .next_stage(next_stage)
  );

  wdg_outputs u_out (
    .clk(clk), .rst_n(rst_n), .expire(expire), .next_stage(next_stage), .cfg(cfg_q),
    .irq_local(irq_local), .irq_fast(irq_fast), .irq_remote(irq_remote),
    .dbg_rst(dbg_rst), .por_rst(por_rst)
  );

  always_comb begin
    unique case (reg_addr)
      A_CFG:   reg_rdata = {{(32-CFG_W){1'b0}}, cfg_q};
      A_STAT:  reg_rdata = {{(31-STAGE_W){1'b0}}, stage_q, run_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               running,
  input logic [STAGE_W-1:0] stage,
  input logic               key,
  input logic [CFG_W-1:0]   cfg,
  input logic               irq_local,
  input logic               irq_fast,
  input logic               irq_remote,
  input logic               dbg_rst,
  input logic               por_rst
);
  // R6
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_rst |=> por_rst);
  // R6
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_rst |=> dbg_rst);
  // R6
  stage_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage <= STAGE_W'(LAST_STG));
  // R5
  irq_when_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_local || irq_fast || irq_remote) |-> $past(running));
  // R7
  stop_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(key));
  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cfg[SRC_W+PER_W]) |=> $stable(cfg));
  // R4
  stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (stage == $past(stage)) || (stage == STAGE_W'($past(stage) + 1))
                || (stage == '0));
endmodule

bind esc_watchdog wdg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .running(run_q), .stage(stage_q), .key(key_q),
  .cfg(cfg_q), .irq_local(irq_local), .irq_fast(irq_fast), .irq_remote(irq_remote),
  .dbg_rst(dbg_rst), .por_rst(por_rst)
);

// File: tb/sim_esc_watchdog.sv
module sim_esc_watchdog;
  localparam int NS = 10;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NS-1:0] tick_src = '0;
  logic irq_local, irq_fast, irq_remote, dbg_rst, por_rst;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  esc_watchdog #(.NUM_SRC(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick_src(tick_src), .irq_local(irq_local), .irq_fast(irq_fast),
    .irq_remote(irq_remote), .dbg_rst(dbg_rst), .por_rst(por_rst)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(int idx);
    @(negedge clk); tick_src[idx] = 1'b1;
    @(negedge clk); tick_src = '0;
  endtask

  function automatic logic [31:0] outs();
    return {27'd0, irq_local, irq_fast, irq_remote, dbg_rst, por_rst};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    check("R1 outputs", outs(), 32'h0);
    rd(2'd0, v); check("R1 cfg", v, 32'h0);
    rd(2'd2, v); check("R1 status", v, 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R2 all ones", v, 32'h0001_FFFF);
    wr(2'd0, 32'h0000_3023); rd(2'd0, v); check("R2 fields", v, 32'h0000_3023);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(2'd1, 32'h1); rd(2'd2, v); check("R3 started", v, 32'h1);
    pulse(5); check("R4 other src irq", outs(), 32'h0);
    rd(2'd2, v); check("R4 other src stage", v, 32'h1);
    pulse(3); check("R4 first of two", outs(), 32'h0);
    pulse(3); check("R5 enabled irqs", outs(), 32'h18);
    @(negedge clk); check("R5 one cycle", outs(), 32'h0);
    rd(2'd2, v); check("R4 stage one", v, 32'h3);
  endtask

  task automatic t_lock_and_stop();
    logic [31:0] v;
    wr(2'd0, 32'h0); rd(2'd0, v); check("R9 locked", v, 32'h0000_3023);
    wr(2'd1, 32'h2); rd(2'd2, v); check("R7 stop no key", v, 32'h3);
    wr(2'd3, 32'h0000_C45A); wr(2'd1, 32'h1);
    rd(2'd2, v); check("R10 restart", v, 32'h1);
    pulse(3); check("R10 count cleared", outs(), 32'h0);
    wr(2'd1, 32'h2); rd(2'd2, v); check("R8 key consumed", v[0], 32'h1);
    wr(2'd3, 32'h0000_1234); wr(2'd1, 32'h2); rd(2'd2, v); check("R7 wrong key", v[0], 32'h1);
    wr(2'd3, 32'h0000_C45A); wr(2'd1, 32'h2); rd(2'd2, v); check("R8 stopped", v[0], 32'h0);
    wr(2'd0, 32'h0001_1000); rd(2'd0, v); check("R9 unlocked write", v, 32'h0001_1000);
  endtask

  task automatic t_final();
    logic [31:0] v;
    wr(2'd1, 32'h1);
    for (int k = 1; k <= 4; k++) begin
      pulse(0); check("R5 local pulse", outs(), 32'h10);
      rd(2'd2, v); check("R4 period zero as one", v, 32'((k << 1) | 1));
    end
    pulse(0); check("R6 por set, no irq", outs(), 32'h1);
    pulse(0); rd(2'd2, v); check("R6 stage held", v, 32'hB);
    check("R6 por held", outs(), 32'h1);
    do_reset(); check("R1 por cleared", outs(), 32'h0);
    wr(2'd0, 32'h0000_8011); wr(2'd1, 32'h1);
    for (int k = 0; k < 5; k++) pulse(1);
    check("R6 dbg only", outs(), 32'h2);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cfg();
    t_count();
    t_lock_and_stop();
    t_final();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule